// File: doc/BRIEF.md
# Multi-Port Reorder Buffer

This block is the in-order window of an out-of-order core. Micro-operations enter it in program order, up to three per clock, and each receives a ring-slot tag. Execution units report results out of order on five independent completion ports. A completion carries the tag, a 32-bit value and two fault flags: an exception and a branch mispredict. The buffer then retires finished entries from the oldest end, up to three per clock. It presents each retired entry's destination register and value to the architectural register file.

A forwarding port lets rename or issue logic ask for the newest in-flight producer of a register. If that producer has already finished, its uncommitted value is returned. When the oldest entry finishes with a fault, every in-flight entry is discarded and a one-cycle flush is signalled. Allocation then resumes at the faulting entry's slot.

Top module: `ooo_reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_tag` is 0, `alloc_ready` is high for any request of 0 to 3, `retire_valid` is all zero, `flush` is low and `fwd_hit` is low.
- R2: When an allocation fires with `alloc_cnt` = n, lane k (k < n, with k = 0 the oldest) takes the destination in bits [k*AREG_W +: AREG_W] of `alloc_dst`. Lane k receives tag (`alloc_tag` + k) mod DEPTH. `alloc_tag` then advances by n modulo DEPTH.
- R3: `alloc_ready` is low, and nothing is allocated, whenever DEPTH minus the current occupancy is less than `alloc_cnt`. Entries retiring in the same cycle are not counted as free.
- R4: A completion on any port whose tag names a live entry marks that entry done and records its value and fault flags. A completion whose tag names an empty slot has no effect on a later occupant of that slot.
- R5: Retirement is strictly in program order, at most 3 per cycle, and stops at the first entry that is not done or that is faulted. `retire_valid` bits are contiguous from bit 0.
- R6: Retire lane k carries the destination register and value of the entry k places behind the oldest one.
- R7: When the oldest entry is done and has its exception or mispredict flag set, `flush` is high for that cycle and nothing retires. On the next cycle the buffer is empty, and the next allocation is given the faulting entry's tag.
- R8: Entries older than a faulting entry retire normally, in the same cycle that the fault reaches them or earlier.
- R9: `fwd_hit` is high when the youngest live entry whose destination equals `fwd_reg` is done; `fwd_value` is then that entry's value. If the youngest match is not done, or there is no match, `fwd_hit` is low.
- R10: `alloc_ready` is low in a flush cycle.
- R11: Occupancy never exceeds DEPTH, it equals the number of live entries, and the allocation tag always equals (oldest tag + occupancy) mod DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_cnt | input | CNT_W | Number of micro-ops to allocate this cycle (0..ALLOC_W) |
| alloc_dst | input | ALLOC_W*AREG_W | Destination registers, lane 0 oldest |
| alloc_ready | output | 1 | Request accepted this cycle |
| alloc_tag | output | IDX_W | Tag given to lane 0 |
| wb_valid | input | WB_PORTS | Completion strobe per port |
| wb_tag | input | WB_PORTS*IDX_W | Completion tag per port |
| wb_value | input | WB_PORTS*DATA_W | Result value per port |
| wb_exc | input | WB_PORTS | Exception flag per port |
| wb_mis | input | WB_PORTS | Mispredict flag per port |
| retire_valid | output | RETIRE_W | Retire strobe per lane |
| retire_dst | output | RETIRE_W*AREG_W | Destination register per lane |
| retire_value | output | RETIRE_W*DATA_W | Result value per lane |
| flush | output | 1 | Discard pulse caused by the oldest entry |
| fwd_reg | input | AREG_W | Register to look up |
| fwd_hit | output | 1 | Youngest producer is done |
| fwd_value | output | DATA_W | Value of that producer |

## Verification
The hardest situation to reach is a fault at the oldest entry on a wrapped ring. In that case older entries must have retired together in the cycle just before, and a fresh allocation lands on the faulting slot after the flush. Stale completions aimed at freed slots must leave no trace on the new occupants.

The bench reaches these states with a small ring of eight slots. It alternates phases that fill the ring with no completions, drain it with heavy completions, and mix both at low and then high fault rates. Destinations are drawn from four registers, so the forwarding port keeps seeing several live producers of the same register.

// File: rtl/ooo_rb_pkg.sv
package ooo_rb_pkg;
   // Ring increment, valid for base < depth and step <= depth.
   function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                            int unsigned depth);
      int unsigned s;
      s = base + step;
      if (s >= depth) s = s - depth;
      return s;
   endfunction
endpackage

// File: rtl/ooo_rb_alloc.sv
module ooo_rb_alloc #(
   parameter int unsigned DEPTH   = 40,
   parameter int unsigned ALLOC_W = 3,
   parameter int unsigned OCC_W   = 6,
   parameter int unsigned CNT_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ_i,
   input  logic [CNT_W-1:0] req_cnt_i,
   input  logic             flush_i,
   output logic             ready_o,
   output logic             fire_o
);
   logic [OCC_W-1:0] free_w;

   assign free_w  = OCC_W'(DEPTH) - occ_i;
   assign ready_o = !flush_i && (free_w >= OCC_W'(req_cnt_i));
   assign fire_o  = ready_o && (req_cnt_i != '0);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> ((32'(occ_i) + 32'(req_cnt_i)) <= DEPTH));
endmodule

// File: rtl/ooo_rb_retire.sv
module ooo_rb_retire #(
   parameter int unsigned DEPTH    = 40,
   parameter int unsigned RETIRE_W = 3,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned OCC_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    head_i,
   input  logic [OCC_W-1:0]    occ_i,
   input  logic [DEPTH-1:0]    done_i,
   input  logic [DEPTH-1:0]    fault_i,
   output logic [RETIRE_W-1:0] lane_ok_o,
   output logic [IDX_W-1:0]    lane_idx_o [RETIRE_W],
   output logic [OCC_W-1:0]    n_ret_o,
   output logic                flush_o
);
   logic run;

   for (genvar k = 0; k < RETIRE_W; k++) begin : g_lane
      assign lane_idx_o[k] = IDX_W'(ooo_rb_pkg::ring_add(32'(head_i), k, DEPTH));
   end

   always_comb begin
      run     = 1'b1;
      n_ret_o = '0;
      for (int k = 0; k < RETIRE_W; k++) begin
         run = run && (k < int'(occ_i)) && done_i[lane_idx_o[k]] && !fault_i[lane_idx_o[k]];
         lane_ok_o[k] = run;
         n_ret_o = n_ret_o + OCC_W'(run);
      end
   end

   assign flush_o = (occ_i != '0) && done_i[head_i] && fault_i[head_i];

   p_flush_blocks_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (lane_ok_o == '0));
endmodule

// File: rtl/ooo_rb_forward.sv
module ooo_rb_forward #(
   parameter int unsigned DEPTH  = 40,
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned OCC_W  = 6,
   parameter int unsigned AREG_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic [IDX_W-1:0]  head_i,
   input  logic [OCC_W-1:0]  occ_i,
   input  logic [DEPTH-1:0]  valid_i,
   input  logic [DEPTH-1:0]  done_i,
   input  logic [AREG_W-1:0] dst_i [DEPTH],
   input  logic [DATA_W-1:0] val_i [DEPTH],
   input  logic [AREG_W-1:0] key_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] value_o
);
   logic             found;
   logic [IDX_W-1:0] sel;
   logic [IDX_W-1:0] scan;

   // Scan from oldest to youngest; the last match wins.
   always_comb begin
      found = 1'b0;
      sel   = '0;
      scan  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         scan = IDX_W'(ooo_rb_pkg::ring_add(32'(head_i), k, DEPTH));
         if ((k < int'(occ_i)) && valid_i[scan] && (dst_i[scan] == key_i)) begin
            found = 1'b1;
            sel   = scan;
         end
      end
   end

   assign hit_o   = found && done_i[sel];
   assign value_o = val_i[sel];
endmodule

// File: rtl/ooo_reorder_buf.sv
module ooo_reorder_buf #(
   parameter int unsigned DEPTH    = 40,
   parameter int unsigned ALLOC_W  = 3,
   parameter int unsigned RETIRE_W = 3,
   parameter int unsigned WB_PORTS = 5,
   parameter int unsigned AREG_W   = 5,
   parameter int unsigned DATA_W   = 32,
   localparam int unsigned IDX_W   = $clog2(DEPTH),
   localparam int unsigned OCC_W   = $clog2(DEPTH + 1),
   localparam int unsigned CNT_W   = $clog2(ALLOC_W + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CNT_W-1:0]             alloc_cnt,
   input  logic [ALLOC_W*AREG_W-1:0]    alloc_dst,
   output logic                         alloc_ready,
   output logic [IDX_W-1:0]             alloc_tag,
   input  logic [WB_PORTS-1:0]          wb_valid,
   input  logic [WB_PORTS*IDX_W-1:0]    wb_tag,
   input  logic [WB_PORTS*DATA_W-1:0]   wb_value,
   input  logic [WB_PORTS-1:0]          wb_exc,
   input  logic [WB_PORTS-1:0]          wb_mis,
   output logic [RETIRE_W-1:0]          retire_valid,
   output logic [RETIRE_W*AREG_W-1:0]   retire_dst,
   output logic [RETIRE_W*DATA_W-1:0]   retire_value,
   output logic                         flush,
   input  logic [AREG_W-1:0]            fwd_reg,
   output logic                         fwd_hit,
   output logic [DATA_W-1:0]            fwd_value
);
   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("ooo_reorder_buf: DEPTH must be at least 2");
   end
   if ((ALLOC_W > DEPTH) || (RETIRE_W > DEPTH)) begin : g_bad_width
      $error("ooo_reorder_buf: port width exceeds DEPTH");
   end
   if (WB_PORTS < 1) begin : g_bad_wb
      $error("ooo_reorder_buf: need at least one completion port");
   end

   // Ring state
   logic [IDX_W-1:0]  head_q, tail_q;
   logic [OCC_W-1:0]  occ_q;
   logic [DEPTH-1:0]  live_q, done_q, exc_q, mis_q;
   logic [AREG_W-1:0] dst_q [DEPTH];
   logic [DATA_W-1:0] val_q [DEPTH];

   logic              fire, flush_w;
   logic [RETIRE_W-1:0] lane_ok;
   logic [IDX_W-1:0]  lane_idx [RETIRE_W];
   logic [OCC_W-1:0]  n_ret, add_cnt;
   logic [IDX_W-1:0]  head_nx, tail_nx;
   logic [IDX_W-1:0]  alloc_idx [ALLOC_W];
   logic [ALLOC_W-1:0] alloc_en;
   logic [IDX_W-1:0]  wb_t [WB_PORTS];
   logic [WB_PORTS-1:0] wb_hit;

   ooo_rb_alloc #(
      .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .OCC_W(OCC_W), .CNT_W(CNT_W)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n), .occ_i(occ_q), .req_cnt_i(alloc_cnt),
      .flush_i(flush_w), .ready_o(alloc_ready), .fire_o(fire)
   );

   ooo_rb_retire #(
      .DEPTH(DEPTH), .RETIRE_W(RETIRE_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
   ) u_retire (
      .clk(clk), .rst_n(rst_n), .head_i(head_q), .occ_i(occ_q),
      .done_i(done_q), .fault_i(exc_q | mis_q),
      .lane_ok_o(lane_ok), .lane_idx_o(lane_idx), .n_ret_o(n_ret), .flush_o(flush_w)
   );

   ooo_rb_forward #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .OCC_W(OCC_W), .AREG_W(AREG_W), .DATA_W(DATA_W)
   ) u_fwd (
      .head_i(head_q), .occ_i(occ_q), .valid_i(live_q), .done_i(done_q),
      .dst_i(dst_q), .val_i(val_q), .key_i(fwd_reg),
      .hit_o(fwd_hit), .value_o(fwd_value)
   );

   // Allocation lanes
   for (genvar k = 0; k < ALLOC_W; k++) begin : g_alloc
      assign alloc_idx[k] = IDX_W'(ooo_rb_pkg::ring_add(32'(tail_q), k, DEPTH));
      assign alloc_en[k]  = fire && (CNT_W'(k) < alloc_cnt);
   end

   // Completion ports
   for (genvar p = 0; p < WB_PORTS; p++) begin : g_wb
      assign wb_t[p]   = wb_tag[p*IDX_W +: IDX_W];
      assign wb_hit[p] = wb_valid[p] && (32'(wb_t[p]) < DEPTH) && live_q[wb_t[p]];
   end

   // Retire lanes
   for (genvar k = 0; k < RETIRE_W; k++) begin : g_ret
      assign retire_valid[k]                   = lane_ok[k];
      assign retire_dst[k*AREG_W +: AREG_W]    = dst_q[lane_idx[k]];
      assign retire_value[k*DATA_W +: DATA_W]  = val_q[lane_idx[k]];
   end

   assign flush     = flush_w;
   assign alloc_tag = tail_q;
   assign add_cnt   = fire ? OCC_W'(alloc_cnt) : '0;
   assign head_nx   = IDX_W'(ooo_rb_pkg::ring_add(32'(head_q), 32'(n_ret), DEPTH));
   assign tail_nx   = IDX_W'(ooo_rb_pkg::ring_add(32'(tail_q), 32'(add_cnt), DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         done_q <= '0;
         exc_q  <= '0;
         mis_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         for (int p = 0; p < WB_PORTS; p++) begin
            if (wb_hit[p]) begin
               done_q[wb_t[p]] <= 1'b1;
               exc_q[wb_t[p]]  <= wb_exc[p];
               mis_q[wb_t[p]]  <= wb_mis[p];
            end
         end
         for (int k = 0; k < ALLOC_W; k++) begin
            if (alloc_en[k]) begin
               live_q[alloc_idx[k]] <= 1'b1;
               done_q[alloc_idx[k]] <= 1'b0;
               exc_q[alloc_idx[k]]  <= 1'b0;
               mis_q[alloc_idx[k]]  <= 1'b0;
            end
         end
         for (int k = 0; k < RETIRE_W; k++) begin
            if (lane_ok[k]) live_q[lane_idx[k]] <= 1'b0;
         end
         if (flush_w) begin
            live_q <= '0;
            tail_q <= head_q;
            occ_q  <= '0;
         end else begin
            head_q <= head_nx;
            tail_q <= tail_nx;
            occ_q  <= occ_q + add_cnt - n_ret;
         end
      end
   end

   // Payload storage, no reset needed
   always_ff @(posedge clk) begin
      for (int p = 0; p < WB_PORTS; p++) begin
         if (wb_hit[p]) val_q[wb_t[p]] <= wb_value[p*DATA_W +: DATA_W];
      end
      for (int k = 0; k < ALLOC_W; k++) begin
         if (alloc_en[k]) dst_q[alloc_idx[k]] <= alloc_dst[k*AREG_W +: AREG_W];
      end
   end

   p_occ_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(DEPTH));
   p_live_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(live_q) == int'(occ_q));
   p_ring_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tail_q == IDX_W'(ooo_rb_pkg::ring_add(32'(head_q), 32'(occ_q), DEPTH)));
   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_w |=> ((occ_q == '0) && (live_q == '0)));
   p_retire_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid[0] |-> (live_q[head_q] && done_q[head_q]));
endmodule

// File: tb/tb_ooo_reorder_buf.sv
module tb_ooo_reorder_buf;
   localparam int CLK_P = 10;
   localparam int D  = 8;
   localparam int AW = 3;
   localparam int CW = 3;
   localparam int WP = 5;
   localparam int RW = 5;
   localparam int DW = 32;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]       alloc_cnt = '0;
   logic [AW*RW-1:0] alloc_dst = '0;
   logic             alloc_ready;
   logic [IW-1:0]    alloc_tag;
   logic [WP-1:0]    wb_valid = '0;
   logic [WP*IW-1:0] wb_tag = '0;
   logic [WP*DW-1:0] wb_value = '0;
   logic [WP-1:0]    wb_exc = '0;
   logic [WP-1:0]    wb_mis = '0;
   logic [CW-1:0]    retire_valid;
   logic [CW*RW-1:0] retire_dst;
   logic [CW*DW-1:0] retire_value;
   logic             flush;
   logic [RW-1:0]    fwd_reg = '0;
   logic             fwd_hit;
   logic [DW-1:0]    fwd_value;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Reference model state
   bit          m_valid [D];
   bit          m_done  [D];
   bit          m_exc   [D];
   bit          m_mis   [D];
   logic [RW-1:0] m_dst [D];
   logic [DW-1:0] m_val [D];
   int m_head = 0, m_tail = 0, m_cnt = 0;
   bit e_flush, e_ready;
   int e_nret;

   ooo_reorder_buf #(
      .DEPTH(D), .ALLOC_W(AW), .RETIRE_W(CW), .WB_PORTS(WP), .AREG_W(RW), .DATA_W(DW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_dst(alloc_dst),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .wb_valid(wb_valid),
      .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc), .wb_mis(wb_mis),
      .retire_valid(retire_valid), .retire_dst(retire_dst), .retire_value(retire_value),
      .flush(flush), .fwd_reg(fwd_reg), .fwd_hit(fwd_hit), .fwd_value(fwd_value)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(int pa, int pw, int pe);
      bit used [D];
      for (int i = 0; i < D; i++) used[i] = 0;
      alloc_cnt = ($urandom_range(0, 99) < pa) ? 2'($urandom_range(1, 3)) : 2'd0;
      for (int k = 0; k < AW; k++) alloc_dst[k*RW +: RW] = RW'($urandom_range(0, 3));
      for (int p = 0; p < WP; p++) begin
         int t;
         wb_valid[p] = 1'b0;
         wb_exc[p]   = 1'b0;
         wb_mis[p]   = 1'b0;
         t = $urandom_range(0, D-1);
         if (($urandom_range(0, 99) < pw) && !used[t] && !(m_valid[t] && m_done[t])) begin
            used[t] = 1;
            wb_valid[p] = 1'b1;
            wb_tag[p*IW +: IW] = IW'(t);
            wb_value[p*DW +: DW] = $urandom;
            wb_exc[p] = ($urandom_range(0, 99) < pe);
            wb_mis[p] = ($urandom_range(0, 99) < pe);
         end
      end
      fwd_reg = RW'($urandom_range(0, 3));
   endtask

   task automatic check_outputs();
      bit run, stop_fault, found;
      int sel;
      e_flush = (m_cnt > 0) && m_done[m_head] && (m_exc[m_head] || m_mis[m_head]);
      e_ready = !e_flush && ((D - m_cnt) >= int'(alloc_cnt));
      if (e_flush) chk("R10 ready low during flush", alloc_ready, 0);
      else         chk("R3 alloc_ready", alloc_ready, e_ready);
      chk("R2 alloc_tag", alloc_tag, m_tail);
      chk("R7 flush", flush, e_flush);
      run = 1; e_nret = 0; stop_fault = 0;
      for (int k = 0; k < CW; k++) begin
         int i;
         i = (m_head + k) % D;
         if (run && k < m_cnt && m_done[i] && (m_exc[i] || m_mis[i])) stop_fault = 1;
         run = run && (k < m_cnt) && m_done[i] && !m_exc[i] && !m_mis[i];
         chk(stop_fault ? "R8 retire before fault" : "R5 retire_valid",
             retire_valid[k], run);
         if (run) begin
            chk("R6 retire_dst", retire_dst[k*RW +: RW], m_dst[i]);
            chk("R4 retire_value", retire_value[k*DW +: DW], m_val[i]);
            e_nret++;
         end
      end
      found = 0; sel = 0;
      for (int k = 0; k < m_cnt; k++) begin
         int i;
         i = (m_head + k) % D;
         if (m_dst[i] == fwd_reg) begin found = 1; sel = i; end
      end
      chk("R9 fwd_hit", fwd_hit, found && m_done[sel]);
      if (found && m_done[sel]) chk("R9 fwd_value", fwd_value, m_val[sel]);
   endtask

   task automatic apply_edge();
      int n;
      for (int p = 0; p < WP; p++) begin
         int t;
         t = int'(wb_tag[p*IW +: IW]);
         if (wb_valid[p] && m_valid[t]) begin
            m_done[t] = 1;
            m_exc[t]  = wb_exc[p];
            m_mis[t]  = wb_mis[p];
            m_val[t]  = wb_value[p*DW +: DW];
         end
      end
      if (e_flush) begin
         for (int i = 0; i < D; i++) m_valid[i] = 0;
         m_tail = m_head;
         m_cnt  = 0;
      end else begin
         n = e_ready ? int'(alloc_cnt) : 0;
         for (int k = 0; k < n; k++) begin
            int i;
            i = (m_tail + k) % D;
            m_valid[i] = 1; m_done[i] = 0; m_exc[i] = 0; m_mis[i] = 0;
            m_dst[i] = alloc_dst[k*RW +: RW];
         end
         for (int k = 0; k < e_nret; k++) m_valid[(m_head + k) % D] = 0;
         m_head = (m_head + e_nret) % D;
         m_tail = (m_tail + n) % D;
         m_cnt  = m_cnt + n - e_nret;
      end
   endtask

   task automatic cycle(int pa, int pw, int pe);
      @(negedge clk);
      drive(pa, pw, pe);
      #1;
      check_outputs();
      @(posedge clk);
      apply_edge();
   endtask

   initial begin
      for (int i = 0; i < D; i++) begin
         m_valid[i] = 0; m_done[i] = 0; m_exc[i] = 0; m_mis[i] = 0;
         m_dst[i] = '0; m_val[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      alloc_cnt = 2'd3;
      #1;
      chk("R1 reset alloc_ready", alloc_ready, 1);
      chk("R1 reset alloc_tag", alloc_tag, 0);
      chk("R1 reset retire_valid", retire_valid, 0);
      chk("R1 reset flush", flush, 0);
      chk("R1 reset fwd_hit", fwd_hit, 0);
      alloc_cnt = 2'd0;
      // Fill with no completions, then confirm a full ring stalls
      repeat (10) cycle(100, 0, 0);
      @(negedge clk);
      alloc_cnt = 2'd1; wb_valid = '0;
      #1;
      chk("R11 full ring stalls", alloc_ready, (m_cnt < D));
      @(posedge clk);
      // Drain, then mixed traffic at low and high fault rates
      repeat (30)   cycle(0, 80, 0);
      repeat (4000) cycle(60, 50, 3);
      repeat (1500) cycle(70, 60, 20);
      repeat (1500) cycle(90, 30, 5);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule